// File: doc/BRIEF.md
# Transmit Frame Queue with Length Commands

This block sits between a host register port and a byte-wide transmit stream. The host first pushes a frame's payload as whole 32-bit words into a data queue, then pushes one command word that gives the frame's byte length and the position of the first valid byte within the first word. Only once that command is queued does the block start unpacking the frame, so a frame is never sent ahead of its description.

The output side delivers one byte per accepted cycle over a valid/ready handshake and marks the final byte of each frame. Because the start offset travels in the command, a buffer that does not begin on a word boundary can be pushed as whole words without any repacking by the host. The host reads the data queue's fill level, compares it against the depth before writing, and can watch an almost-empty flag set against a level it chooses. A flush input discards everything queued, including a frame that is partly sent.

Top module: `tx_frame_queue`

## Requirements
- R1: The command word carries the frame length in bytes in bits 15:0 and the start offset in bits 17:16. Data words are unpacked little-endian (byte 0 in bits 7:0). The first offset bytes of the first word are skipped, and the next `length` bytes are sent in order.
- R2: No byte of a frame appears on `out_valid` until its command word has been written, even when all of its data words are already queued.
- R3: A frame consumes exactly floor((length + offset + 3) / 4) data words. The bytes of the last word that lie past the length are discarded, and the next frame starts on a fresh word.
- R4: `out_last` is high on the final byte of each frame and on no other byte. The cycle after that byte is accepted, `out_valid` is low.
- R5: While `out_valid` is high and `out_ready` is low, `out_byte` and `out_last` hold their values.
- R6: `word_count` gives the number of data words held, and it changes in the cycle after the write or pop that alters it.
- R7: `almost_empty` is high exactly when `word_count` is less than or equal to `ae_level`.
- R8: `data_full` is high when `word_count` equals DATA_DEPTH, and `cmd_full` is high when the command queue is full. A write to a full queue is dropped and raises `overflow` for the single following cycle.
- R9: While `flush` is high, both queues are emptied, a frame in progress is abandoned, and writes are ignored. In the cycle after, `word_count` is 0 and `out_valid` is low.
- R10: Synchronous reset leaves `word_count` at 0, `out_valid` and `overflow` low, and `data_full` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties both queues while high |
| data_wr | input | 1 | Push `data_in` into the data queue |
| data_in | input | 32 | Payload word, byte 0 in bits 7:0 |
| cmd_wr | input | 1 | Push `cmd_in` into the command queue |
| cmd_in | input | 18 | Offset in bits 17:16, length in bits 15:0 |
| ae_level | input | $clog2(DATA_DEPTH+1) | Almost-empty level |
| word_count | output | $clog2(DATA_DEPTH+1) | Data words held |
| almost_empty | output | 1 | `word_count` <= `ae_level` |
| data_full | output | 1 | Data queue full |
| cmd_full | output | 1 | Command queue full |
| overflow | output | 1 | One-cycle pulse after a dropped write |
| out_valid | output | 1 | `out_byte` is valid |
| out_byte | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| out_ready | input | 1 | Sink accepts the byte |

## Verification
The assertions assume that the host follows the queue discipline: every command has a length of at least one, and all of the data words for a frame are written before its command. Under that discipline, the word count at the end of each frame matches the word-count formula. The stimulus always builds a frame's words from its length and offset before it issues the command. It uses only non-zero lengths, and it checks fullness by filling the data queue without any command, so no pop can hide a dropped write. Backpressure is applied by toggling `out_ready` away from the clock edge, which exercises the hold rule while data is queued.

// File: rtl/txq_pkg.sv
package txq_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 16;
  localparam int OFS_W  = 2;
  localparam int CMD_W  = LEN_W + OFS_W;
  localparam int BYTES  = WORD_W / 8;

  // Offset sits above length: bits 17:16 and 15:0 of the command word.
  typedef struct packed {
    logic [OFS_W-1:0] ofs;
    logic [LEN_W-1:0] len;
  } txq_cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMD   = 2'd1,
    ST_FETCH = 2'd2,
    ST_SEND  = 2'd3
  } txq_state_t;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         wr_en,
  input  logic [WIDTH-1:0]             wr_data,
  input  logic                         rd_en,
  output logic [WIDTH-1:0]             rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             wr_ok, rd_ok;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  // Storage without reset and with a registered read port, so it maps to RAM.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      count <= count + CW'(wr_ok) - CW'(rd_ok);
    end
  end
endmodule

// File: rtl/txq_unpacker.sv
module txq_unpacker
  import txq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cmd_empty,
  output logic              cmd_rd,
  input  txq_cmd_t          cmd_word,
  input  logic              data_empty,
  output logic              data_rd,
  input  logic [WORD_W-1:0] data_word,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  output logic              out_last,
  input  logic              out_ready
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int IW = $clog2(BYTES);

  txq_state_t     st;
  logic [LEN_W-1:0] rem;
  logic [IW-1:0]    idx;

  always_comb begin
    cmd_rd    = (st == ST_IDLE)  && !cmd_empty;
    data_rd   = (st == ST_FETCH) && !data_empty;
    out_valid = (st == ST_SEND);
    out_byte  = data_word[{idx, 3'b000} +: 8];
    out_last  = out_valid && (rem == LEN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st  <= ST_IDLE;
      rem <= '0;
      idx <= '0;
    end else begin
      case (st)
        ST_IDLE:  if (!cmd_empty) st <= ST_CMD;
        ST_CMD: begin
          rem <= cmd_word.len;
          idx <= IW'(cmd_word.ofs);
          st  <= (cmd_word.len == '0) ? ST_IDLE : ST_FETCH;
        end
        ST_FETCH: if (!data_empty) st <= ST_SEND;
        ST_SEND: begin
          if (out_ready) begin
            rem <= rem - 1'b1;
            if (rem == LEN_W'(1)) begin
              st  <= ST_IDLE;
            end else if (idx == IW'(BYTES-1)) begin
              idx <= '0;
              st  <= ST_FETCH;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_frame_queue.sv
module tx_frame_queue
  import txq_pkg::*;
#(
  parameter int DATA_DEPTH = 64,
  parameter int CMD_DEPTH  = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              flush,
  input  logic                              data_wr,
  input  logic [31:0]                       data_in,
  input  logic                              cmd_wr,
  input  logic [17:0]                       cmd_in,
  input  logic [$clog2(DATA_DEPTH+1)-1:0]   ae_level,
  output logic [$clog2(DATA_DEPTH+1)-1:0]   word_count,
  output logic                              almost_empty,
  output logic                              data_full,
  output logic                              cmd_full,
  output logic                              overflow,
  output logic                              out_valid,
  output logic [7:0]                        out_byte,
  output logic                              out_last,
  input  logic                              out_ready
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CCW = $clog2(CMD_DEPTH+1);

  logic              cmd_empty, data_empty, cmd_rd, data_rd;
  logic [CMD_W-1:0]  cmd_q;
  logic [WORD_W-1:0] data_q;
  logic [CCW-1:0]    cmd_count;
  txq_cmd_t          cmd_s;

  txq_fifo #(.WIDTH(WORD_W), .DEPTH(DATA_DEPTH)) data_q_i (
    .clk(clk), .rst(rst), .clr(flush),
    .wr_en(data_wr && !flush), .wr_data(data_in),
    .rd_en(data_rd), .rd_data(data_q),
    .count(word_count), .full(data_full), .empty(data_empty)
  );

  txq_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) cmd_q_i (
    .clk(clk), .rst(rst), .clr(flush),
    .wr_en(cmd_wr && !flush), .wr_data(cmd_in),
    .rd_en(cmd_rd), .rd_data(cmd_q),
    .count(cmd_count), .full(cmd_full), .empty(cmd_empty)
  );

  assign cmd_s = txq_cmd_t'(cmd_q);

  txq_unpacker unpack_i (
    .clk(clk), .rst(rst), .clr(flush),
    .cmd_empty(cmd_empty), .cmd_rd(cmd_rd), .cmd_word(cmd_s),
    .data_empty(data_empty), .data_rd(data_rd), .data_word(data_q),
    .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last),
    .out_ready(out_ready)
  );

  assign almost_empty = (word_count <= ae_level);

  always_ff @(posedge clk) begin
    if (rst) overflow <= 1'b0;
    else     overflow <= !flush && ((data_wr && data_full) || (cmd_wr && cmd_full));
  end
endmodule

// File: rtl/tx_frame_queue_chk.sv
module tx_frame_queue_chk #(
  parameter int DATA_DEPTH = 64
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            flush,
  input logic                            data_wr,
  input logic                            data_full,
  input logic                            overflow,
  input logic [$clog2(DATA_DEPTH+1)-1:0] word_count,
  input logic                            out_valid,
  input logic [7:0]                      out_byte,
  input logic                            out_last,
  input logic                            out_ready
);
  timeunit 1ns;
  timeprecision 1ps;

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_byte) && $stable(out_last));

  assert_last_end_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last && !flush |=> !out_valid);

  assert_drop_flag_R8: assert property (@(posedge clk) disable iff (rst)
    data_wr && data_full && !flush |=> overflow);

  assert_flush_clear_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (word_count == '0) && !out_valid);
endmodule

bind tx_frame_queue tx_frame_queue_chk #(.DATA_DEPTH(DATA_DEPTH)) chk_i (
  .clk(clk), .rst(rst), .flush(flush), .data_wr(data_wr), .data_full(data_full),
  .overflow(overflow), .word_count(word_count), .out_valid(out_valid),
  .out_byte(out_byte), .out_last(out_last), .out_ready(out_ready)
);

// File: tb/tx_frame_queue_tb_top.sv
module tx_frame_queue_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DD = 64;
  localparam int CW = $clog2(DD+1);
  // Each row: length, offset, seed.
  localparam int VEC [7][3] = '{'{1,0,3}, '{4,0,4}, '{5,3,5}, '{7,1,6},
                                '{2,2,7}, '{13,3,8}, '{8,0,2}};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1, flush = 1'b0, data_wr = 1'b0, cmd_wr = 1'b0;
  logic [31:0]   data_in = '0;
  logic [17:0]   cmd_in = '0;
  logic [CW-1:0] ae_level = '0;
  logic [CW-1:0] word_count;
  logic          almost_empty, data_full, cmd_full, overflow;
  logic          out_valid, out_last, out_ready = 1'b0;
  logic [7:0]    out_byte;

  tx_frame_queue #(.DATA_DEPTH(DD), .CMD_DEPTH(8)) dut_i (
    .clk(clk), .rst(rst), .flush(flush), .data_wr(data_wr), .data_in(data_in),
    .cmd_wr(cmd_wr), .cmd_in(cmd_in), .ae_level(ae_level), .word_count(word_count),
    .almost_empty(almost_empty), .data_full(data_full), .cmd_full(cmd_full),
    .overflow(overflow), .out_valid(out_valid), .out_byte(out_byte),
    .out_last(out_last), .out_ready(out_ready)
  );

  int tests = 0, fails = 0;
  int rdy_mode = 0;  // 0 low, 1 high, 2 toggling
  logic [7:0] rx_b [0:511];
  logic       rx_l [0:511];
  int         rx_n = 0;

  always @(posedge clk) begin
    #1;
    out_ready = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? ~out_ready : 1'b0;
  end

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready && rx_n < 512) begin
      rx_b[rx_n] = out_byte;
      rx_l[rx_n] = out_last;
      rx_n = rx_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'(seed * 16 + k * 7 + 1);
  endfunction

  task automatic push_word(input logic [31:0] w);
    @(negedge clk); data_wr = 1'b1; data_in = w;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic push_data(input int seed, input int len, input int ofs);
    for (int w = 0; w < (len + ofs + 3) / 4; w++)
      push_word({pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)});
  endtask

  task automatic push_cmd(input int len, input int ofs);
    @(negedge clk); cmd_wr = 1'b1; cmd_in = {ofs[1:0], len[15:0]};
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wait_bytes(input int n, input string req);
    int t = 0;
    while (rx_n < n && t < 2000) begin @(posedge clk); t++; end
    if (rx_n < n) check(1'b0, req, "byte count timeout", rx_n, n);
    @(negedge clk);
  endtask

  task automatic check_frame(input int seed, input int len, input int ofs,
                             input int base, input string req);
    bit ok = 1'b1;
    int a = 0, e = 0;
    for (int k = 0; k < len; k++) begin
      if (ok && rx_b[base+k] != pat(seed, ofs+k)) begin
        ok = 1'b0; a = rx_b[base+k]; e = pat(seed, ofs+k);
      end
      if (ok && rx_l[base+k] != (k == len-1)) begin
        ok = 1'b0; a = rx_l[base+k]; e = (k == len-1);
      end
    end
    check(ok, req, $sformatf("frame seed %0d byte/last", seed), a, e);
  endtask

  task automatic do_flush(input bit also_write);
    @(negedge clk); flush = 1'b1; data_wr = also_write; data_in = 32'hDEAD_BEEF;
    @(negedge clk); flush = 1'b0; data_wr = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(word_count == 0, "R10", "word_count", int'(word_count), 0);
    check(!out_valid, "R10", "out_valid", out_valid, 0);
    check(!overflow, "R10", "overflow", overflow, 0);
    check(!data_full, "R10", "data_full", data_full, 0);
    check(almost_empty, "R7", "almost_empty at zero", almost_empty, 1);

    // Table of frames: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 7; i++) begin
      rdy_mode = (i % 2 == 1) ? 2 : 1;
      @(posedge clk); base = rx_n;
      push_data(VEC[i][2], VEC[i][0], VEC[i][1]);
      repeat (3) @(negedge clk);
      check(rx_n == base && !out_valid, "R2", "bytes before command", rx_n - base, 0);
      check(int'(word_count) == (VEC[i][0] + VEC[i][1] + 3) / 4, "R6", "word_count",
            int'(word_count), (VEC[i][0] + VEC[i][1] + 3) / 4);
      push_cmd(VEC[i][0], VEC[i][1]);
      wait_bytes(base + VEC[i][0], "R1");
      check_frame(VEC[i][2], VEC[i][0], VEC[i][1], base, (i % 2 == 1) ? "R5" : "R1");
      check(word_count == 0, "R3", "words left after frame", int'(word_count), 0);
    end
    rdy_mode = 1;

    // R7 almost-empty level
    ae_level = CW'(2);
    push_word(32'h1); push_word(32'h2);
    check(almost_empty, "R7", "ae at count 2 level 2", almost_empty, 1);
    push_word(32'h3);
    check(!almost_empty, "R7", "ae at count 3 level 2", almost_empty, 0);
    @(negedge clk); ae_level = CW'(3);
    @(negedge clk);
    check(almost_empty, "R7", "ae at count 3 level 3", almost_empty, 1);
    do_flush(1'b0);
    check(word_count == 0, "R9", "count after flush", int'(word_count), 0);

    // R8 full and overflow
    for (int w = 0; w < DD; w++) push_word(32'(w));
    check(data_full, "R8", "data_full", data_full, 1);
    check(int'(word_count) == DD, "R8", "count when full", int'(word_count), DD);
    push_word(32'hFFFF_FFFF);
    check(overflow, "R8", "overflow pulse", overflow, 1);
    check(int'(word_count) == DD, "R8", "count after dropped write", int'(word_count), DD);
    @(negedge clk);
    check(!overflow, "R8", "overflow one cycle", overflow, 0);
    do_flush(1'b0);
    check(word_count == 0 && !data_full, "R9", "full cleared by flush", int'(word_count), 0);

    // R9 flush abandons a frame in progress; writes during flush ignored
    rdy_mode = 0;
    push_data(9, 6, 0);
    push_cmd(6, 0);
    repeat (4) @(negedge clk);
    check(out_valid, "R9", "frame pending before flush", out_valid, 1);
    do_flush(1'b1);
    check(!out_valid, "R9", "out_valid after flush", out_valid, 0);
    check(word_count == 0, "R9", "write during flush ignored", int'(word_count), 0);
    @(posedge clk); base = rx_n;
    rdy_mode = 1;
    repeat (10) @(negedge clk);
    check(rx_n == base, "R9", "abandoned frame bytes", rx_n - base, 0);
    push_data(12, 3, 1);
    push_cmd(3, 1);
    wait_bytes(base + 3, "R9");
    check_frame(12, 3, 1, base, "R9");

    // R3 two queued frames, first with trailing discard
    rdy_mode = 0;
    @(posedge clk); base = rx_n;
    push_data(10, 5, 2); push_cmd(5, 2);
    push_data(11, 3, 1); push_cmd(3, 1);
    rdy_mode = 1;
    wait_bytes(base + 8, "R3");
    check_frame(10, 5, 2, base, "R3");
    check_frame(11, 3, 1, base + 5, "R3");
    check(word_count == 0, "R3", "words left after pair", int'(word_count), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule